// File: doc/BRIEF.md
# External Data Memory Bus Sequencer

This block runs one external data memory transfer at a time on a bus with separate address and data lines. The core gives a one-clock start pulse with a direction bit, a 20-bit address and a write byte. The sequencer then drives the address port and places the active-low read or write strobe at fixed offsets, counted in input clock periods. For writes it also controls the output enable of the bidirectional data port. When the transfer ends it gives a one-clock done pulse. After a read, the byte it captured is held on its read-data output.

A transfer has three parts. The address is set up for 4 periods, the strobe is low for 6 periods, and one hold period follows. A start pulse is taken only while the sequencer is idle. The program-fetch path, the choice of address source and the pad buffers are outside this block.

Top module: `xdm_bus_seq`

## Requirements
- R1: After reset, rd_n_o and wr_n_o are high, data_oe_o is low and done_o is low.
- R2: addr_o shows the address captured with an accepted start. It holds that address from the first clock after the accepting edge until the end of the hold period.
- R3: For a read (write_i=0), rd_n_o goes low 4 clock periods after the address appears. It stays low for exactly 6 periods.
- R4: data_i is sampled at the clock edge that ends the read strobe. rdata_o shows that byte from that edge onward.
- R5: For a write (write_i=1), wr_n_o goes low 4 periods after the address appears and stays low for exactly 6 periods.
- R6: data_oe_o is high only during a write. It rises 1 period before wr_n_o falls and falls 1 period after wr_n_o rises. While it is high, data_o carries the captured write byte.
- R7: done_o is high for exactly one clock, in the first period after the strobe returns high.
- R8: A start pulse that arrives while a transfer is in progress is ignored. The address does not change and no further strobe follows.
- R9: rdata_o keeps its value until the next read completes. A write does not change it.
- R10: rd_n_o and wr_n_o are never low at the same time, and data_oe_o is never high while rd_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock request to begin a transfer |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Transfer address |
| wdata_i | input | 8 | Write byte |
| data_i | input | 8 | Byte read from the data port |
| addr_o | output | 20 | Address port |
| data_o | output | 8 | Byte driven onto the data port |
| data_oe_o | output | 1 | Output enable for the data port |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| done_o | output | 1 | One-clock end-of-transfer pulse |
| rdata_o | output | 8 | Last byte captured by a read |

## Verification
Count clock edges from the edge that accepts start, calling it edge 0. The address is valid after edge 0. The write data enable rises after edge 3. The strobe is low after edges 4 through 9. The read byte is captured and done rises at edge 10. The sequencer is idle again after edge 11. The bench drives its inputs and samples the outputs on falling edges. In each transfer it compares every output against these edge counts, one falling edge at a time. It also changes data_i after edge 10, so a late sample would be caught.

// File: rtl/xdm_pkg.sv
package xdm_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_STRB  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/xdm_req_latch.sv
module xdm_req_latch
    import xdm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  xfer_t req_in,
    output xfer_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/xdm_phase_seq.sv
module xdm_phase_seq
    import xdm_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int STRB_CYC  = 6,
    parameter int HOLD_CYC  = 1,
    parameter int LEAD_CYC  = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output logic   accept,
    output phase_e phase,
    output logic   cnt_zero,
    output logic   in_lead
);
    localparam int MAXC = max3(SETUP_CYC, STRB_CYC, HOLD_CYC);
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic [CW-1:0] cnt;

    assign accept   = start && (phase == PH_IDLE);
    assign cnt_zero = (cnt == '0);
    assign in_lead  = (phase == PH_SETUP) && (int'(cnt) < LEAD_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= CW'(SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_STRB;
                        cnt   <= CW'(STRB_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STRB: begin
                    if (cnt_zero) begin
                        phase <= PH_HOLD;
                        cnt   <= CW'(HOLD_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xdm_rd_capture.sv
module xdm_rd_capture
    import xdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (sample) begin
            held <= bus_in;
        end
    end
endmodule

// File: rtl/xdm_bus_seq.sv
module xdm_bus_seq
    import xdm_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int STRB_CYC  = 6,
    parameter int HOLD_CYC  = 1,
    parameter int LEAD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    xfer_t  req_in, req_q;
    phase_e phase;
    logic   accept, cnt_zero, in_lead, strobe_on;

    assign req_in = '{wr: write_i, addr: addr_i, wdata: wdata_i};

    xdm_phase_seq #(
        .SETUP_CYC(SETUP_CYC),
        .STRB_CYC (STRB_CYC),
        .HOLD_CYC (HOLD_CYC),
        .LEAD_CYC (LEAD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .accept  (accept),
        .phase   (phase),
        .cnt_zero(cnt_zero),
        .in_lead (in_lead)
    );

    xdm_req_latch u_req (
        .clk   (clk),
        .rst   (rst),
        .accept(accept),
        .req_in(req_in),
        .req_q (req_q)
    );

    xdm_rd_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .sample(strobe_on && cnt_zero && !req_q.wr),
        .bus_in(data_i),
        .held  (rdata_o)
    );

    assign strobe_on = (phase == PH_STRB);
    assign addr_o    = req_q.addr;
    assign data_o    = req_q.wdata;
    assign rd_n_o    = !(strobe_on && !req_q.wr);
    assign wr_n_o    = !(strobe_on && req_q.wr);
    assign data_oe_o = req_q.wr && (in_lead || strobe_on || phase == PH_HOLD);
    assign done_o    = (phase == PH_HOLD) && cnt_zero;
endmodule

// File: rtl/xdm_bus_seq_chk.sv
module xdm_bus_seq_chk
    import xdm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_o,
    input logic              data_oe_o,
    input logic              rd_n_o,
    input logic              wr_n_o,
    input logic              done_o
);
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));
    a_r10_no_oe_on_read: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !data_oe_o);
    a_r6_oe_under_write: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> data_oe_o);
    a_r7_done_one_clock: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (rd_n_o && wr_n_o));
    a_r2_addr_stable_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o || !wr_n_o) |=> $stable(addr_o));
endmodule

bind xdm_bus_seq xdm_bus_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr_o   (addr_o),
    .data_oe_o(data_oe_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .done_o   (done_o)
);

// File: tb/test_xdm_bus_seq.sv
module test_xdm_bus_seq;
    localparam int AW = 20;
    localparam int DW = 8;
    localparam int NV = 5;
    // vector: {write, addr, wdata, bus read value}
    localparam logic [AW+2*DW:0] VEC [NV] = '{
        {1'b0, 20'h2_0000, 8'h00, 8'h5A},
        {1'b1, 20'h3_0000, 8'hC3, 8'h11},
        {1'b0, 20'hF_FF00, 8'h00, 8'hA7},
        {1'b1, 20'h0_1200, 8'h3C, 8'hEE},
        {1'b0, 20'h4_4001, 8'hFF, 8'h00}
    };

    logic          clk = 0, rst = 1, start_i = 0, write_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0, data_i = '0;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] data_o, rdata_o;
    logic          data_oe_o, rd_n_o, wr_n_o, done_o;
    int            n_cmp = 0, n_bad = 0;
    logic [DW-1:0] last_rd = '0;

    always #4 clk = ~clk;

    xdm_bus_seq i_xdm_bus_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .write_i(write_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .data_i(data_i),
        .addr_o(addr_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .done_o(done_o), .rdata_o(rdata_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // caller is at a falling edge; transfer's accepting edge is the next rising edge
    task automatic run_xfer(input logic w, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                            input logic poke);
        start_i = 1; write_i = w; addr_i = a; wdata_i = wd; data_i = rv;
        for (int k = 0; k <= 11; k++) begin
            @(negedge clk);
            start_i = 0;
            if (poke && k == 5) begin
                start_i = 1; write_i = !w; addr_i = ~a;
            end
            if (k <= 10) chk("R2 addr", 32'(addr_o), 32'(a));
            chk("R3 rd_n", 32'(rd_n_o), 32'(!(!w && k >= 4 && k <= 9)));
            chk("R5 wr_n", 32'(wr_n_o), 32'(!(w && k >= 4 && k <= 9)));
            chk("R6 oe", 32'(data_oe_o), 32'(w && k >= 3 && k <= 10));
            if (data_oe_o) chk("R6 data_o", 32'(data_o), 32'(wd));
            chk("R7 done", 32'(done_o), 32'(k == 10));
            if (k == 10) begin
                if (!w) last_rd = rv;
                data_i = ~rv;
                chk(w ? "R9 rdata kept" : "R4 rdata", 32'(rdata_o), 32'(last_rd));
            end
            if (k == 11) chk("R4 rdata held", 32'(rdata_o), 32'(last_rd));
        end
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_n", 32'(rd_n_o), 32'd1);
        chk("R1 wr_n", 32'(wr_n_o), 32'd1);
        chk("R1 oe", 32'(data_oe_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        rst = 0;
        @(negedge clk);
        // table walk, back to back: next start at the falling edge after idle
        for (int v = 0; v < NV; v++) begin
            run_xfer(VEC[v][AW+2*DW], VEC[v][AW+2*DW-1:2*DW],
                     VEC[v][2*DW-1:DW], VEC[v][DW-1:0], 1'b0);
        end
        // R8: start during a read is ignored
        run_xfer(1'b0, 20'h1_2345, 8'h00, 8'h96, 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R8 no rd", 32'(rd_n_o), 32'd1);
            chk("R8 no wr", 32'(wr_n_o), 32'd1);
            chk("R8 addr", 32'(addr_o), 32'h1_2345);
        end
        // R8: start during a write is ignored
        run_xfer(1'b1, 20'hA_BCDE, 8'h81, 8'h00, 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R8 idle oe", 32'(data_oe_o), 32'd0);
            chk("R8 addr w", 32'(addr_o), 32'hA_BCDE);
        end
        // R10: check strobes never overlap during a read after a write
        run_xfer(1'b0, 20'h0_0000, 8'h00, 8'h01, 1'b0);
        chk("R10 final", 32'(rd_n_o & wr_n_o), 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule